// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is an SPI master that runs a fixed 8-bit word in mode 0: the serial clock idles low, the master changes MOSI after a falling edge of the serial clock, and it samples MISO on the rising edge, most significant bit first. The serial clock comes from the system clock through an even divider set by a parameter. Slave select is one active-low output. It is asserted while any word is loaded for sending.

Both directions have two stages. On the transmit side, a write lands in the shift stage at once when the block is idle. While a word is shifting, a second write waits in a holding stage, and three flags report its state: transmit empty, transmit full and receive empty. When the current word ends, the queued word moves up and starts after a suspend gap. A 4-bit input sets the gap length in half-periods of the serial clock. During the gap, slave select stays asserted.

On the receive side, each finished word is copied into a holding stage that software reads. If software has not read that stage yet, the word stays in the shift stage. No further word is clocked until a read frees the holding stage, so no received data is ever overwritten.

Top module: `spi_dbuf_master`

## Requirements
- R1: After reset, txEmpty=1, txFull=0, rxEmpty=1, csN=1 and sclk=0. Whenever csN is high, sclk is low.
- R2: A write (wrEn high at a clock edge) while txEmpty=1 loads the word for sending. txEmpty goes to 0 and csN goes low at that edge, and the word is shifted out on MOSI, bit 7 first.
- R3: A write while txEmpty=0 and txFull=0 is kept in the holding stage and sets txFull. A write while txFull=1 is dropped and is never sent. txFull=1 never occurs together with txEmpty=1.
- R4: When a word ends with a queued word, the queued word is sent next and txFull returns to 0. A write that arrives on the very edge where a word ends is sent next in the same way, and txFull stays 0.
- R5: Between two queued words, csN stays low and sclk stays low for exactly gapCfg*H + H + 1 system clocks, where H = CLK_DIV/2.
- R6: Each sclk half-period is H system clocks. MOSI never changes while sclk is high. MISO is sampled at each rising sclk edge, bit 7 first.
- R7: When a word ends while rxEmpty=1, the received word appears on rdData and rxEmpty goes to 0.
- R8: While rxEmpty=0 and no read is made, rdData does not change. A word that ends in this state is held back, and no further word starts (sclk stays low) until a read is made.
- R9: A read (rdEn high at an edge) while rxEmpty=0 sets rxEmpty to 1. A held-back word is placed on rdData one cycle later, and rxEmpty returns to 0. A read while rxEmpty=1 has no effect.
- R10: When a word ends with no word queued, txEmpty returns to 1 and csN goes high at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe for a transmit word |
| wrData | input | 8 | Transmit word |
| rdEn | input | 1 | Read strobe; removes the word shown on rdData |
| rdData | output | 8 | Word in the receive holding stage |
| gapCfg | input | 4 | Suspend gap between queued words, in sclk half-periods |
| txEmpty | output | 1 | No word is loaded for sending |
| txFull | output | 1 | Transmit holding stage is occupied |
| rxEmpty | output | 1 | Receive holding stage has no unread word |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 1 | Active-low slave select |

## Verification
A software write and the end of the current word can fall on the same system clock edge. In that case the new word has to bypass the holding stage: it is promoted without txFull ever being set, and slave select must not be released. The bench counts the serial clock edges of the running word. From that count it computes the edge of the final falling edge and raises wrEn for that single edge only. It then judges that txFull stays 0 and csN stays low, and that the slave model receives the written word as the next word after the normal gap.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_XFER
  } ctrlState_t;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic loadBus;   // shift stage <- wrData
    logic loadHold;  // shift stage <- holding stage
    logic holdWr;    // holding stage <- wrData
    logic shiftTx;   // advance transmit shift stage
    logic sampleRx;  // shift miso into receive stage
    logic copyRx;    // receive holding <- receive shift
  } dpStrobe_t;

endpackage

// File: rtl/spi_dbuf_dp.sv
module spi_dbuf_dp
  import spi_dbuf_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [WORD_W-1:0] wrData,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rdData
);

  logic [WORD_W-1:0] txShift, txHold, rxShift, rxHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      txHold  <= '0;
    end else begin
      if (stb.holdWr) txHold <= wrData;
      if (stb.loadBus)       txShift <= wrData;
      else if (stb.loadHold) txShift <= txHold;
      else if (stb.shiftTx)  txShift <= {txShift[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxHold  <= '0;
    end else begin
      if (stb.sampleRx) rxShift <= {rxShift[WORD_W-2:0], miso};
      if (stb.copyRx)   rxHold  <= rxShift;
    end
  end

  assign mosi   = txShift[WORD_W-1];
  assign rdData = rxHold;

endmodule

// File: rtl/spi_dbuf_ctrl.sv
module spi_dbuf_ctrl
  import spi_dbuf_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int WORD_W  = 8,
  parameter int GAP_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [GAP_W-1:0] gapCfg,
  output dpStrobe_t        stb,
  output logic             txEmpty,
  output logic             txFull,
  output logic             rxEmpty,
  output logic             sclk,
  output logic             csN
);

  localparam int HALF  = CLK_DIV / 2;
  localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int PH_W  = $clog2(2 * WORD_W);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(2 * WORD_W - 1);

  ctrlState_t       state;
  logic [DIV_W-1:0] divCnt;
  logic [PH_W-1:0]  phase;
  logic [GAP_W-1:0] gapLeft;
  logic             rxPending;

  logic halfTick, inXfer, wordDone, rdAccept, nextQueued;

  always_comb begin
    halfTick   = (divCnt == DIV_LAST);
    inXfer     = (state == ST_XFER);
    wordDone   = inXfer && halfTick && (phase == PH_LAST);
    rdAccept   = rdEn && !rxEmpty;
    nextQueued = txFull || wrEn;

    stb.loadBus  = wrEn && (txEmpty || (wordDone && !txFull));
    stb.holdWr   = wrEn && !txEmpty && !txFull && !wordDone;
    stb.loadHold = wordDone && txFull;
    stb.sampleRx = inXfer && halfTick && !phase[0];
    stb.shiftTx  = inXfer && halfTick && phase[0] && !wordDone;
    stb.copyRx   = rxEmpty && (wordDone || rxPending);
  end

  // sequencing of words, gap and serial clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      phase   <= '0;
      gapLeft <= '0;
      sclk    <= 1'b0;
      txEmpty <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (wrEn) begin
            state   <= ST_WAIT;
            gapLeft <= '0;
            divCnt  <= '0;
            txEmpty <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (gapLeft == '0) begin
            if (!rxPending) begin
              state  <= ST_XFER;
              divCnt <= '0;
              phase  <= '0;
            end
          end else if (halfTick) begin
            divCnt  <= '0;
            gapLeft <= gapLeft - 1'b1;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_XFER: begin
          if (halfTick) begin
            divCnt <= '0;
            phase  <= phase + 1'b1;
            sclk   <= !phase[0];
            if (wordDone) begin
              sclk <= 1'b0;
              if (nextQueued) begin
                state   <= ST_WAIT;
                gapLeft <= gapCfg;
              end else begin
                state   <= ST_IDLE;
                txEmpty <= 1'b1;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // buffer flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txFull    <= 1'b0;
      rxEmpty   <= 1'b1;
      rxPending <= 1'b0;
    end else begin
      if (stb.holdWr)        txFull <= 1'b1;
      else if (stb.loadHold) txFull <= 1'b0;

      if (rdAccept)        rxEmpty <= 1'b1;
      else if (stb.copyRx) rxEmpty <= 1'b0;

      if (wordDone && !rxEmpty)         rxPending <= 1'b1;
      else if (rxPending && rxEmpty)    rxPending <= 1'b0;
    end
  end

  assign csN = (state == ST_IDLE);

endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master
  import spi_dbuf_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int WORD_W  = 8,
  parameter int GAP_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData,
  input  logic [GAP_W-1:0]  gapCfg,
  output logic              txEmpty,
  output logic              txFull,
  output logic              rxEmpty,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              csN
);

  dpStrobe_t stb;

  spi_dbuf_ctrl #(
    .CLK_DIV(CLK_DIV),
    .WORD_W (WORD_W),
    .GAP_W  (GAP_W)
  ) ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .gapCfg (gapCfg),
    .stb    (stb),
    .txEmpty(txEmpty),
    .txFull (txFull),
    .rxEmpty(rxEmpty),
    .sclk   (sclk),
    .csN    (csN)
  );

  spi_dbuf_dp #(
    .WORD_W(WORD_W)
  ) dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .wrData(wrData),
    .miso  (miso),
    .mosi  (mosi),
    .rdData(rdData)
  );

endmodule

// File: rtl/spi_dbuf_master_chk.sv
module spi_dbuf_master_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic [WORD_W-1:0] rdData,
  input logic              txEmpty,
  input logic              txFull,
  input logic              rxEmpty,
  input logic              sclk,
  input logic              mosi,
  input logic              csN
);

  // R1
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  // R10
  select_tracks_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty == csN);

  // R3
  full_not_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    txFull |-> !txEmpty);

  // R6
  mosi_stable_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R8
  rx_hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEmpty && !rdEn) |=> $stable(rdData));

  // R9
  pop_sets_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEmpty && rdEn) |=> rxEmpty);

endmodule

bind spi_dbuf_master spi_dbuf_master_chk #(.WORD_W(WORD_W)) chk (
  .clk    (clk),
  .rstN   (rstN),
  .rdEn   (rdEn),
  .rdData (rdData),
  .txEmpty(txEmpty),
  .txFull (txFull),
  .rxEmpty(rxEmpty),
  .sclk   (sclk),
  .mosi   (mosi),
  .csN    (csN)
);

// File: tb/spi_dbuf_master_test.sv
`timescale 1ns/1ps
module spi_dbuf_master_test;

  localparam int CLK_DIV = 4;
  localparam int HALF    = CLK_DIV / 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic [3:0] gapCfg = '0;
  logic       txEmpty, txFull, rxEmpty, sclk, mosi, miso, csN;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_dbuf_master #(.CLK_DIV(CLK_DIV)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .gapCfg(gapCfg), .txEmpty(txEmpty), .txFull(txFull),
    .rxEmpty(rxEmpty), .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN)
  );

  // slave model: captures mosi on rising sclk, shifts miso on falling sclk
  logic [7:0] slvRx [0:31];
  logic [7:0] slvIn = '0;
  logic [7:0] slvSh;
  int rxCnt = 0;
  int inBits = 0;
  int outBits = 0;
  int outIdx = 0;

  function automatic logic [7:0] misoWord(int i);
    return 8'h3C ^ 8'(i * 37);
  endfunction

  initial slvSh = misoWord(0);
  assign miso = slvSh[7];

  always @(posedge sclk) begin
    slvIn = {slvIn[6:0], mosi};
    inBits++;
    if (inBits == 8) begin
      slvRx[rxCnt] = slvIn;
      rxCnt++;
      inBits = 0;
    end
  end

  always @(negedge sclk) begin
    outBits++;
    if (outBits == 8) begin
      outBits = 0;
      outIdx++;
      slvSh = misoWord(outIdx);
    end else begin
      slvSh = {slvSh[6:0], 1'b0};
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeWord(input logic [7:0] b);
    @(negedge clk); wrEn = 1'b1; wrData = b;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic readWord();
    @(negedge clk); rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (!txEmpty && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic waitRx(input int target);
    int n = 0;
    while (rxCnt < target && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    check(txEmpty == 1'b1, "R1 txEmpty", int'(txEmpty), 1);
    check(txFull == 1'b0, "R1 txFull", int'(txFull), 0);
    check(rxEmpty == 1'b1, "R1 rxEmpty", int'(rxEmpty), 1);
    check(csN == 1'b1, "R1 csN", int'(csN), 1);
    check(sclk == 1'b0, "R1 sclk", int'(sclk), 0);
  endtask

  task automatic t_single();
    int base = rxCnt;
    int hi = 0;
    logic [7:0] held;
    writeWord(8'hA5);
    check(txEmpty == 1'b0 && csN == 1'b0, "R2 start flags", {txEmpty, csN}, 0);
    while (!sclk) @(negedge clk);
    while (sclk) begin hi++; @(negedge clk); end
    check(hi == HALF, "R6 half-period", hi, HALF);
    waitIdle();
    check(slvRx[base] == 8'hA5, "R2 mosi word", slvRx[base], 8'hA5);
    check(csN == 1'b1, "R10 csN released", int'(csN), 1);
    check(rxEmpty == 1'b0, "R7 rxEmpty", int'(rxEmpty), 0);
    check(rdData == misoWord(base), "R7 R6 rdData", rdData, misoWord(base));
    readWord();
    check(rxEmpty == 1'b1, "R9 pop", int'(rxEmpty), 1);
    held = rdData;
    readWord();
    @(negedge clk);
    check(rxEmpty == 1'b1 && rdData == held, "R9 empty read ignored", rdData, held);
  endtask

  task automatic t_gap(input logic [3:0] g);
    int base = rxCnt;
    int lowCnt = 0;
    int csHigh = 0;
    int expLow = int'(g) * HALF + HALF + 1;
    gapCfg = g;
    writeWord(8'h11 + 8'(g));
    writeWord(8'h5A);
    check(txFull == 1'b1, "R3 txFull set", int'(txFull), 1);
    writeWord(8'hEE);
    waitRx(base + 1);
    while (sclk) @(negedge clk);
    check(txFull == 1'b0, "R4 txFull cleared", int'(txFull), 0);
    while (!sclk) begin
      lowCnt++;
      if (csN) csHigh++;
      @(negedge clk);
    end
    check(lowCnt == expLow, "R5 gap length", lowCnt, expLow);
    check(csHigh == 0, "R5 csN held", csHigh, 0);
    waitIdle();
    repeat (20) @(negedge clk);
    check(rxCnt == base + 2, "R3 full write dropped", rxCnt - base, 2);
    check(slvRx[base + 1] == 8'h5A, "R4 queued word", slvRx[base + 1], 8'h5A);
    check(rdData == misoWord(base), "R8 first kept", rdData, misoWord(base));
    readWord();
    @(negedge clk);
    check(rxEmpty == 1'b0 && rdData == misoWord(base + 1), "R9 refill",
          rdData, misoWord(base + 1));
    readWord();
  endtask

  task automatic t_rx_hold();
    int base = rxCnt;
    int n = 0;
    gapCfg = 4'd1;
    writeWord(8'hC3);
    writeWord(8'h96);
    while (txFull && n < 5000) begin @(negedge clk); n++; end
    writeWord(8'h0F);
    waitRx(base + 2);
    repeat (40) @(negedge clk);
    check(rxCnt == base + 2 && sclk == 1'b0 && csN == 1'b0, "R8 stall",
          rxCnt - base, 2);
    check(rdData == misoWord(base), "R8 held word", rdData, misoWord(base));
    readWord();
    @(negedge clk);
    check(rdData == misoWord(base + 1), "R9 pending copy", rdData, misoWord(base + 1));
    waitIdle();
    repeat (4) @(negedge clk);
    check(slvRx[base + 2] == 8'h0F, "R8 resumed word", slvRx[base + 2], 8'h0F);
    check(rdData == misoWord(base + 1), "R8 no overwrite", rdData, misoWord(base + 1));
    readWord();
    @(negedge clk);
    check(rdData == misoWord(base + 2), "R9 third word", rdData, misoWord(base + 2));
    readWord();
  endtask

  task automatic t_coincident();
    int base = rxCnt;
    gapCfg = 4'd2;
    writeWord(8'h3E);
    waitRx(base + 1);
    repeat (HALF - 1) @(negedge clk);
    wrEn = 1'b1; wrData = 8'hB7;
    @(negedge clk);
    wrEn = 1'b0;
    check(txFull == 1'b0, "R4 same-edge write bypasses", int'(txFull), 0);
    check(csN == 1'b0 && txEmpty == 1'b0, "R4 select held", {csN, txEmpty}, 0);
    waitIdle();
    check(rxCnt == base + 2, "R4 word count", rxCnt - base, 2);
    check(slvRx[base + 1] == 8'hB7, "R4 same-edge word", slvRx[base + 1], 8'hB7);
    readWord();
    @(negedge clk);
    readWord();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_single();
    t_gap(4'd0);
    t_gap(4'd3);
    t_rx_hold();
    t_coincident();
    repeat (4) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule